// File: doc/BRIEF.md
# Offset-Binary Sine Lookup

This block turns a 13-bit phase word into a 12-bit sine amplitude. The phase covers one full turn in 8192 steps, so a phase of 0 is 0 degrees and 0x1000 is 180 degrees. The amplitude is an unsigned offset-binary code centred at 0x800. The code 0x000 never appears, so the swing stays within 0x001..0xFFF and is point-symmetric about the midpoint. The block sits between a phase accumulator and a digital-to-analog converter in a direct digital synthesis path.

Only one quarter of the wave is stored. It is a table of 2048 eleven-bit magnitudes that the design computes at elaboration with fixed-point arithmetic, so no data file is needed. The top phase bit picks the half-wave sign. The next bit mirrors the table index inside the half-wave. The magnitude is then added to or taken from the midpoint. A phase word marked by a valid strobe gives its amplitude two clock edges later. Between valid words the output holds its last value.

Top module: `offset_sine_lookup`

## Requirements
- R1: While reset is asserted, and on leaving it, `amp_o` is 0x800 and `amp_vld_o` is 0.
- R2: A phase presented with `phase_vld_i` = 1 at a rising edge produces its amplitude, with `amp_vld_o` = 1, right after the second rising edge. `amp_vld_o` is `phase_vld_i` delayed by two edges.
- R3: Phases 0x0000 and 0x1000 (0 and 180 degrees) both give 0x800.
- R4: Phase 0x0800 (90 degrees) gives 0xFFF and phase 0x1800 (270 degrees) gives 0x001.
- R5: The amplitude code 0x000 is never produced.
- R6: In the first quadrant (phase bits 12 and 11 both 0), the output is 0x800 + m. Here m is within 1 of round(2047 * sin(2*pi*p/8192)).
- R7: When phase bit 11 is 1, the magnitude equals the one at the first-quadrant phase whose bits 10..0 are the bitwise inverse. So the output for phase {bit12, 1, i} equals the output for phase {bit12, 0, ~i}.
- R8: Phase bit 12 selects the sign. The output for phase p + 0x1000 equals 0x1000 minus the output for phase p, for every p below 0x1000.
- R9: While `phase_vld_i` is 0, `amp_o` keeps its last value whatever `phase_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_i | input | 13 | Phase word, 8192 steps per turn |
| phase_vld_i | input | 1 | Marks `phase_i` as a word to convert |
| amp_o | output | 12 | Sine amplitude, offset binary |
| amp_vld_o | output | 1 | Marks `amp_o` as a fresh result |

## Verification
The hardest point to reach is the quadrant seam, where the mirrored index and the sign meet. Near 90 and 270 degrees the table is read at its last entry. Near 0 and 180 degrees it is read at entry 0. An off-by-one in the mirroring or in the subtraction only shows at these few phases. The bench therefore streams every one of the 8192 phases back to back and stores the results. It then checks each mirrored pair and each opposite-sign pair exactly against the stored first-quadrant values. The first quadrant itself is compared with a real-valued sine computed in the bench.

// File: rtl/offset_sine_lookup.sv
module offset_sine_lookup #(
  parameter int PHASE_W = 13,
  parameter int AMP_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               phase_vld_i,
  output logic [AMP_W-1:0]   amp_o,
  output logic               amp_vld_o
);
  localparam int IDX_W   = PHASE_W - 2;
  localparam int DEPTH   = 1 << IDX_W;
  localparam int MAG_W   = AMP_W - 1;
  localparam int MAG_MAX = (1 << MAG_W) - 1;
  localparam int MID     = 1 << MAG_W;
  localparam longint PI_Q30 = 64'sd3373259426;

  function automatic logic [MAG_W-1:0] quarter_mag(input int k);
    longint x, x2, term, acc, scaled;
    x    = (longint'(k) * PI_Q30) >>> (PHASE_W - 1);
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int n = 1; n <= 6; n++) begin
      term = -(((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1)));
      acc  = acc + term;
    end
    scaled = (acc * longint'(MAG_MAX) + (64'sd1 <<< 29)) >>> 30;
    if (scaled > longint'(MAG_MAX)) scaled = longint'(MAG_MAX);
    if (scaled < 0) scaled = 0;
    return scaled[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] qtab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    assign qtab[k] = quarter_mag(k);
  end

  wire              mirror = phase_i[PHASE_W-2];
  wire              neg    = phase_i[PHASE_W-1];
  wire [IDX_W-1:0]  idx    = mirror ? ~phase_i[IDX_W-1:0] : phase_i[IDX_W-1:0];

  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      neg_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= phase_vld_i;
      if (phase_vld_i) begin
        mag_q <= qtab[idx];
        neg_q <= neg;
      end
    end
  end

  wire [AMP_W-1:0] mag_ext = {1'b0, mag_q};
  wire [AMP_W-1:0] amp_d   = neg_q ? AMP_W'(MID) - mag_ext : AMP_W'(MID) + mag_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_o     <= AMP_W'(MID);
      amp_vld_o <= 1'b0;
    end else begin
      amp_vld_o <= vld_q;
      if (vld_q) amp_o <= amp_d;
    end
  end
endmodule

// File: rtl/offset_sine_lookup_chk.sv
module offset_sine_lookup_chk #(
  parameter int PHASE_W = 13,
  parameter int AMP_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PHASE_W-1:0] phase_i,
  input logic               phase_vld_i,
  input logic [AMP_W-1:0]   amp_o,
  input logic               amp_vld_o
);
  localparam logic [PHASE_W-1:0] QTR = PHASE_W'(1) << (PHASE_W - 2);
  localparam logic [PHASE_W-1:0] HLF = PHASE_W'(1) << (PHASE_W - 1);
  localparam logic [AMP_W-1:0]   MID = AMP_W'(1) << (AMP_W - 1);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  wire warm = (age >= 2'd2);

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (amp_vld_o == $past(phase_vld_i, 2)));

  assert_no_zero_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    amp_o != '0);

  assert_midpoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(phase_vld_i, 2) && $past(phase_i[PHASE_W-2:0], 2) == '0) |-> (amp_o == MID));

  assert_top_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(phase_vld_i, 2) && $past(phase_i, 2) == QTR) |-> (amp_o == '1));

  assert_bottom_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(phase_vld_i, 2) && $past(phase_i, 2) == (HLF | QTR)) |-> (amp_o == AMP_W'(1)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(phase_vld_i, 2)) |-> $stable(amp_o));
endmodule

bind offset_sine_lookup offset_sine_lookup_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (.*);

// File: tb/test_offset_sine_lookup.sv
`timescale 1ns/1ps
module test_offset_sine_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] phase_i = '0;
  logic        phase_vld_i = 1'b0;
  logic [11:0] amp_o;
  logic        amp_vld_o;

  int n_tests = 0;
  int n_fail  = 0;
  int res [8192];
  bit done = 0;

  always #2 clk = ~clk;

  offset_sine_lookup i_offset_sine_lookup (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .phase_vld_i(phase_vld_i),
    .amp_o(amp_o), .amp_vld_o(amp_vld_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ideal(input int p);
    real v;
    v = 2047.0 * $sin(2.0 * 3.14159265358979 * p / 8192.0);
    return $rtoi(v + 0.5);
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    chk(amp_o == 12'h800, "R1 reset amp", amp_o, 12'h800);
    chk(amp_vld_o == 1'b0, "R1 reset vld", amp_vld_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(amp_o == 12'h800 && !amp_vld_o, "R1 after reset", amp_o, 12'h800);

    phase_i = 13'h0800; phase_vld_i = 1'b1;
    @(negedge clk);
    phase_vld_i = 1'b0;
    chk(amp_vld_o == 1'b0, "R2 one edge", amp_vld_o, 0);
    @(negedge clk);
    chk(amp_vld_o == 1'b1, "R2 two edges", amp_vld_o, 1);
    chk(amp_o == 12'hFFF, "R2 latency value", amp_o, 12'hFFF);
    @(negedge clk);
    chk(amp_vld_o == 1'b0, "R2 pulse ends", amp_vld_o, 0);

    got = 0;
    fork
      begin
        for (int i = 0; i < 8192; i++) begin
          phase_i = 13'(i); phase_vld_i = 1'b1;
          @(negedge clk);
        end
        phase_vld_i = 1'b0;
      end
      begin
        while (got < 8192) begin
          @(negedge clk);
          if (amp_vld_o) begin
            res[got] = int'(amp_o);
            got++;
          end
        end
      end
    join

    chk(res[0] == 12'h800, "R3 phase 0", res[0], 12'h800);
    chk(res[4096] == 12'h800, "R3 phase 0x1000", res[4096], 12'h800);
    chk(res[2048] == 12'hFFF, "R4 phase 0x0800", res[2048], 12'hFFF);
    chk(res[6144] == 12'h001, "R4 phase 0x1800", res[6144], 12'h001);

    begin
      int zeros;
      zeros = 0;
      for (int i = 0; i < 8192; i++) if (res[i] == 0) zeros++;
      chk(zeros == 0, "R5 zero codes", zeros, 0);
    end

    for (int i = 0; i < 2048; i++) begin
      int e, d;
      e = 2048 + ideal(i);
      d = res[i] - e;
      chk(d >= -1 && d <= 1, $sformatf("R6 phase 0x%0h", i), res[i], e);
    end

    for (int i = 0; i < 2048; i++) begin
      chk(res[2048 + i] == res[2047 - i], $sformatf("R7 phase 0x%0h", 2048 + i),
          res[2048 + i], res[2047 - i]);
    end

    for (int i = 0; i < 4096; i++) begin
      chk(res[4096 + i] == 4096 - res[i], $sformatf("R8 phase 0x%0h", 4096 + i),
          res[4096 + i], 4096 - res[i]);
    end

    phase_i = 13'h0800; phase_vld_i = 1'b1;
    @(negedge clk);
    phase_vld_i = 1'b0; phase_i = 13'h1800;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      phase_i = 13'(k * 977);
      chk(amp_o == 12'hFFF, "R9 hold value", amp_o, 12'hFFF);
      chk(amp_vld_o == 1'b0, "R9 no strobe", amp_vld_o, 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule